// File: doc/BRIEF.md
# Synthesizer Channel Control Registers with Deferred Commit

This block is the programming front end of a fractional-N frequency synthesizer. A three-wire serial port (clock, data, load enable) delivers 24-bit words. The three low bits of each word pick one of three registers. The division register carries the integer and fractional divide values. The loop register and the timer register are staged in shadow copies. They reach the active outputs only when the next accepted division-register word commits them.

The serial port runs in its own clock domain. A toggle handshake carries each completed word into the phase-detector clock domain. Every decoded field therefore changes on the same phase-detector edge.

Each accepted channel change starts a fast-lock sequence. A charge-pump boost flag forces the current code to its maximum value, and two loop-switch controls are held closed. Each of the three is released by its own down-counter, counted in phase-detector cycles. A division word with an out-of-range integer, or with a fraction not below the staged modulus, is refused and raises a sticky error.

Top module: `synth_ctrl_regbank`

## Requirements
- R1: Serial data is sampled on each rising edge of `ser_clk`, most significant bit first. The word is taken on the rising edge of `ser_le`. A frame with fewer or more than 24 clock pulses since the previous `ser_le` rise is dropped and changes no register.
- R2: Word bits [2:0] select the target register: 0 selects the division register, 1 the loop register and 2 the timer register. The values 3 to 7 are ignored.
- R3: In a division word, bits [23:15] are the integer value and bits [14:3] are the fractional numerator.
- R4: `int_val` and `frac_val` are updated together on a single phase-detector edge, a fixed three `pfd_clk` edges after the toggle handshake is launched.
- R5: The loop word holds the modulus in bits [14:3] and the charge-pump current code in bits [18:15]. Neither `mod_val` nor `cp_current` changes until an accepted division word commits them.
- R6: The timer word holds three 7-bit timeouts: the charge-pump timeout in bits [9:3], the SW1/SW2 timeout in bits [16:10] and the SW3 timeout in bits [23:17]. They take effect only when a division word commits.
- R7: A division word whose integer is below 26, or whose fraction is not below the staged modulus, is refused. `cfg_error` rises and stays high until reset. Active values are kept, and no fast-lock sequence starts.
- R8: An accepted division word raises `cp_boost` for exactly as many `pfd_clk` cycles as the charge-pump timeout. While the flag is high, `cp_current` reads 15.
- R9: `sw12_closed` and `sw3_closed` stay high for exactly their own timeout counts after an accepted division word, independently of `cp_boost`.
- R10: An accepted division word that arrives during fast lock reloads all three counters from the staged timeouts.
- R11: After reset, `int_val` is 26, `frac_val` is 0, `mod_val` is 4095, `cp_current` is 0, and every flag output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pfd_clk | input | 1 | Phase-detector clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load enable; its rising edge ends a frame |
| int_val | output | 9 | Active integer divide value |
| frac_val | output | 12 | Active fractional numerator |
| mod_val | output | 12 | Active modulus |
| cp_current | output | 4 | Charge-pump current code |
| cp_boost | output | 1 | Charge-pump boost in progress |
| sw12_closed | output | 1 | SW1/SW2 loop switches closed |
| sw3_closed | output | 1 | SW3 loop switch closed |
| cfg_error | output | 1 | Sticky refused-division-word flag |

## Verification
Division words are sent alone, after a loop word and after a timer word. These cases separate an immediate update from a deferred commit of staged values. Short timeouts that differ per counter are measured cycle by cycle, which shows that each release is independent and that the current is forced during boost. Back-to-back division words with long timeouts show that a restart reloads the counters rather than letting them run out. Frames of 23 and 25 pulses, a reserved select code, an integer of 25 and a fraction equal to the modulus each test a refusal path against its neighbouring accepted value.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int WORD_W   = 24;
  localparam int CTRL_W   = 3;
  localparam int INT_W    = 9;
  localparam int FRAC_W   = 12;
  localparam int CP_W     = 4;
  localparam int TO_W     = 7;
  localparam int NUM_TO   = 3;
  localparam int INT_LSB  = 15;
  localparam int FRAC_LSB = 3;
  localparam int MOD_LSB  = 3;
  localparam int CPC_LSB  = 15;
  localparam int TO_LSB   = 3;
  localparam int TO_SPAN  = NUM_TO * TO_W;
  localparam logic [INT_W-1:0] INT_MIN = INT_W'(26);

  typedef enum logic [CTRL_W-1:0] {
    SEL_DIV   = 3'd0,
    SEL_LOOP  = 3'd1,
    SEL_TIMER = 3'd2
  } reg_sel_e;

  // A division word is accepted only if both the integer and fraction are in range.
  function automatic logic div_word_legal(input logic [INT_W-1:0] n,
                                          input logic [FRAC_W-1:0] f,
                                          input logic [FRAC_W-1:0] m);
    return (n >= INT_MIN) && (f < m);
  endfunction
endpackage

// File: rtl/sreg_serial_rx.sv
module sreg_serial_rx #(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 8
) (
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [WORD_W-1:0] word_q,
  output logic              req_tgl
);
  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  edge_cnt;
  logic [CNT_W-1:0]  last_cnt;
  logic              frame_ok;

  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      edge_cnt <= '0;
    end else begin
      shift_q  <= {shift_q[WORD_W-2:0], ser_data};
      edge_cnt <= edge_cnt + CNT_W'(1);
    end
  end

  // Pulses since the previous load-enable rise must equal the word width.
  assign frame_ok = (CNT_W'(edge_cnt - last_cnt) == CNT_W'(WORD_W));

  always_ff @(posedge ser_le or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      req_tgl  <= 1'b0;
      last_cnt <= '0;
    end else begin
      last_cnt <= edge_cnt;
      if (frame_ok) begin
        word_q  <= shift_q;
        req_tgl <= ~req_tgl;
      end
    end
  end
endmodule

// File: rtl/sreg_toggle_sync.sv
module sreg_toggle_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);
  logic [2:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], tgl_in};
  end

  assign pulse = sync_q[2] ^ sync_q[1];
endmodule

// File: rtl/sreg_lock_timer.sv
module sreg_lock_timer #(
  parameter int TO_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [TO_W-1:0] load_val,
  output logic            active
);
  logic [TO_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - TO_W'(1);
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/synth_ctrl_regbank.sv
module synth_ctrl_regbank
  import synth_cfg_pkg::*;
#(
  parameter int                INT_RST = 26,
  parameter int                MOD_RST = 4095,
  parameter int                CNT_W   = 8
) (
  input  logic              pfd_clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [INT_W-1:0]  int_val,
  output logic [FRAC_W-1:0] frac_val,
  output logic [FRAC_W-1:0] mod_val,
  output logic [CP_W-1:0]   cp_current,
  output logic              cp_boost,
  output logic              sw12_closed,
  output logic              sw3_closed,
  output logic              cfg_error
);
  logic [WORD_W-1:0]  rx_word;
  logic               rx_tgl;
  logic               word_pulse;
  logic [CTRL_W-1:0]  sel;
  logic               wr_div, wr_loop, wr_timer;
  logic [INT_W-1:0]   new_int;
  logic [FRAC_W-1:0]  new_frac;
  logic               commit, reject;
  logic [FRAC_W-1:0]  sh_mod;
  logic [CP_W-1:0]    sh_cp;
  logic [TO_SPAN-1:0] sh_to;
  logic [CP_W-1:0]    act_cp;
  logic [NUM_TO-1:0]  t_active;

  sreg_serial_rx #(.WORD_W(WORD_W), .CNT_W(CNT_W)) rx_i (
    .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .word_q(rx_word), .req_tgl(rx_tgl)
  );

  sreg_toggle_sync sync_i (
    .clk(pfd_clk), .rst_n(rst_n), .tgl_in(rx_tgl), .pulse(word_pulse)
  );

  // Decode in the phase-detector domain; rx_word is stable while the toggle crosses.
  assign sel      = rx_word[CTRL_W-1:0];
  assign wr_div   = word_pulse && (sel == SEL_DIV);
  assign wr_loop  = word_pulse && (sel == SEL_LOOP);
  assign wr_timer = word_pulse && (sel == SEL_TIMER);
  assign new_int  = rx_word[INT_LSB +: INT_W];
  assign new_frac = rx_word[FRAC_LSB +: FRAC_W];
  assign commit   = wr_div &&  div_word_legal(new_int, new_frac, sh_mod);
  assign reject   = wr_div && !div_word_legal(new_int, new_frac, sh_mod);

  // Shadow copies of the loop and timer registers.
  always_ff @(posedge pfd_clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_mod <= FRAC_W'(MOD_RST);
      sh_cp  <= '0;
      sh_to  <= '0;
    end else begin
      if (wr_loop) begin
        sh_mod <= rx_word[MOD_LSB +: FRAC_W];
        sh_cp  <= rx_word[CPC_LSB +: CP_W];
      end
      if (wr_timer) sh_to <= rx_word[TO_LSB +: TO_SPAN];
    end
  end

  // Active values change only on an accepted division word.
  always_ff @(posedge pfd_clk or negedge rst_n) begin
    if (!rst_n) begin
      int_val   <= INT_W'(INT_RST);
      frac_val  <= '0;
      mod_val   <= FRAC_W'(MOD_RST);
      act_cp    <= '0;
      cfg_error <= 1'b0;
    end else begin
      if (commit) begin
        int_val  <= new_int;
        frac_val <= new_frac;
        mod_val  <= sh_mod;
        act_cp   <= sh_cp;
      end
      if (reject) cfg_error <= 1'b1;
    end
  end

  // One timeout counter per fast-lock output: 0 charge pump, 1 SW1/SW2, 2 SW3.
  for (genvar gi = 0; gi < NUM_TO; gi++) begin : g_timer
    sreg_lock_timer #(.TO_W(TO_W)) tmr_i (
      .clk(pfd_clk), .rst_n(rst_n), .start(commit),
      .load_val(sh_to[gi*TO_W +: TO_W]), .active(t_active[gi])
    );
  end

  assign cp_boost    = t_active[0];
  assign sw12_closed = t_active[1];
  assign sw3_closed  = t_active[2];
  assign cp_current  = cp_boost ? {CP_W{1'b1}} : act_cp;
endmodule

// File: rtl/synth_ctrl_regbank_chk.sv
module synth_ctrl_regbank_chk
  import synth_cfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              commit,
  input logic              reject,
  input logic [INT_W-1:0]  int_val,
  input logic [FRAC_W-1:0] frac_val,
  input logic [FRAC_W-1:0] mod_val,
  input logic              cp_boost,
  input logic              sw3_closed,
  input logic              cfg_error
);
  p_pair_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(int_val) || !$stable(frac_val)) |-> $past(commit));

  p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mod_val) |-> $past(commit));

  p_reject_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> ($stable(int_val) && $stable(frac_val) && cfg_error));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |=> cfg_error);

  p_int_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int_val >= INT_MIN);

  p_frac_below_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frac_val < mod_val);

  p_boost_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cp_boost) |-> $past(commit));

  p_sw3_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw3_closed) |-> $past(commit));
endmodule

bind synth_ctrl_regbank synth_ctrl_regbank_chk chk_i (
  .clk(pfd_clk), .rst_n(rst_n), .commit(commit), .reject(reject),
  .int_val(int_val), .frac_val(frac_val), .mod_val(mod_val),
  .cp_boost(cp_boost), .sw3_closed(sw3_closed), .cfg_error(cfg_error)
);

// File: tb/synth_ctrl_regbank_tb.sv
module synth_ctrl_regbank_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam time SER_HALF   = 10ns;

  logic        pfd_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_data = 1'b0;
  logic        ser_le  = 1'b0;
  logic [8:0]  int_val;
  logic [11:0] frac_val, mod_val;
  logic [3:0]  cp_current;
  logic        cp_boost, sw12_closed, sw3_closed, cfg_error;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) pfd_clk = ~pfd_clk;

  synth_ctrl_regbank dut_i (
    .pfd_clk(pfd_clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .int_val(int_val), .frac_val(frac_val), .mod_val(mod_val),
    .cp_current(cp_current), .cp_boost(cp_boost), .sw12_closed(sw12_closed),
    .sw3_closed(sw3_closed), .cfg_error(cfg_error)
  );

  function automatic logic [23:0] w_div(input int n, input int f);
    return {9'(n), 12'(f), 3'd0};
  endfunction
  function automatic logic [23:0] w_loop(input int m, input int cp);
    return {5'd0, 4'(cp), 12'(m), 3'd1};
  endfunction
  function automatic logic [23:0] w_timer(input int t_cp, input int t12, input int t3);
    return {7'(t3), 7'(t12), 7'(t_cp), 3'd2};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  // Shift npulses bits; pulses beyond 24 shift leading zeros first.
  task automatic send_frame(input logic [23:0] w, input int npulses);
    for (int i = 0; i < npulses; i++) begin
      int idx;
      idx = npulses - 1 - i;
      ser_data = (idx < 24) ? w[idx] : 1'b0;
      #SER_HALF ser_clk = 1'b1;
      #SER_HALF ser_clk = 1'b0;
    end
    #SER_HALF ser_le = 1'b1;
    #SER_HALF ser_le = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge pfd_clk);
  endtask

  task automatic count_flags(input int window, output int n_cp, output int n12,
                             output int n3, output int n_badcur);
    n_cp = 0; n12 = 0; n3 = 0; n_badcur = 0;
    for (int c = 0; c < window; c++) begin
      @(negedge pfd_clk);
      if (cp_boost) n_cp++;
      if (sw12_closed) n12++;
      if (sw3_closed) n3++;
      if (cp_boost && cp_current != 4'd15) n_badcur++;
    end
  endtask

  task automatic test_reset;
    chk_eq("R11 int after reset", int_val, 26);
    chk_eq("R11 frac after reset", frac_val, 0);
    chk_eq("R11 mod after reset", mod_val, 4095);
    chk_eq("R11 cp_current after reset", cp_current, 0);
    chk_eq("R11 flags after reset", {cp_boost, sw12_closed, sw3_closed, cfg_error}, 0);
  endtask

  task automatic test_div_write;
    send_frame(w_div(100, 1234), 24);
    settle(8);
    chk_eq("R3 int field", int_val, 100);
    chk_eq("R4 frac field", frac_val, 1234);
    chk_eq("R8 zero timeout gives no boost", cp_boost, 0);
  endtask

  task automatic test_shadow;
    send_frame(w_loop(2000, 6), 24);
    settle(8);
    chk_eq("R5 mod held in shadow", mod_val, 4095);
    chk_eq("R5 cp code held in shadow", cp_current, 0);
    send_frame(w_div(300, 1999), 24);
    settle(8);
    chk_eq("R5 mod committed", mod_val, 2000);
    chk_eq("R5 cp code committed", cp_current, 6);
    chk_eq("R2 int from division select", int_val, 300);
  endtask

  task automatic test_timeouts;
    int a, b, c, bad;
    send_frame(w_timer(5, 9, 14), 24);
    settle(8);
    chk_eq("R6 timer word alone starts nothing", {cp_boost, sw12_closed, sw3_closed}, 0);
    fork
      send_frame(w_div(301, 10), 24);
      count_flags(150, a, b, c, bad);
    join
    chk_eq("R8 cp_boost cycles", a, 5);
    chk_eq("R9 sw12 closed cycles", b, 9);
    chk_eq("R9 sw3 closed cycles", c, 14);
    chk_eq("R8 current forced to max during boost", bad, 0);
    chk_eq("R8 current returns to code", cp_current, 6);
  endtask

  task automatic test_restart;
    send_frame(w_timer(100, 110, 120), 24);
    send_frame(w_div(302, 11), 24);
    send_frame(w_div(303, 12), 24);
    settle(75);
    chk_eq("R10 counters reloaded, all still active",
           {cp_boost, sw12_closed, sw3_closed}, 7);
    settle(60);
    chk_eq("R10 all released after reload", {cp_boost, sw12_closed, sw3_closed}, 0);
    chk_eq("R10 int of second word", int_val, 303);
  endtask

  task automatic test_framing;
    send_frame(w_div(400, 20), 23);
    settle(8);
    chk_eq("R1 23-pulse frame dropped", int_val, 303);
    send_frame(w_div(401, 21), 25);
    settle(8);
    chk_eq("R1 25-pulse frame dropped", int_val, 303);
    send_frame(w_div(402, 22), 24);
    settle(8);
    chk_eq("R1 good frame after bad ones", int_val, 402);
    settle(140);
  endtask

  task automatic test_ignored_sel;
    logic [23:0] w;
    w = w_loop(500, 3);
    w[2:0] = 3'd5;
    send_frame(w, 24);
    send_frame(w_div(403, 23), 24);
    settle(8);
    chk_eq("R2 reserved select leaves shadow modulus", mod_val, 2000);
    chk_eq("R2 reserved select leaves cp code", cp_boost ? 6 : cp_current, 6);
    settle(140);
  endtask

  task automatic test_legality;
    send_frame(w_div(26, 1999), 24);
    settle(140);
    chk_eq("R7 boundary int 26 and frac mod-1 accepted", int_val, 26);
    chk_eq("R7 no error on boundary", cfg_error, 0);
    fork
      send_frame(w_div(25, 5), 24);
      settle(70);
    join
    chk_eq("R7 int 25 refused", int_val, 26);
    chk_eq("R7 frac kept on refusal", frac_val, 1999);
    chk_eq("R7 error raised", cfg_error, 1);
    chk_eq("R7 refusal starts no fast lock", cp_boost, 0);
    send_frame(w_div(50, 2000), 24);
    settle(8);
    chk_eq("R7 frac equal to modulus refused", int_val, 26);
    chk_eq("R7 error stays set", cfg_error, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    settle(4);
    rst_n = 1'b1;
    settle(2);
    test_reset();
    test_div_write();
    test_shadow();
    test_timeouts();
    test_restart();
    test_framing();
    test_ignored_sel();
    test_legality();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule